// File: doc/BRIEF.md
# Pattern and Qualified Trigger

This block turns a small group of comparator outputs into a trigger decision. Each comparator bit is either ignored or compared against a required level, and the pattern counts as present only when every compared bit agrees. In the two pattern modes the one-cycle trigger pulse marks the moment the pattern appears or the moment it disappears.

In the two qualified modes the pattern does not trigger by itself. It enables a separate source bit, whose selected edge produces the trigger. In the state form the pattern must still hold when that edge arrives. In the edge form the appearance of the pattern is enough, and one trigger then uses up that permission. An optional wait, by elapsed cycles or by a count of source edges, can delay the trigger. An optional window can also cap how late the edge may come. Both measures restart every time the pattern appears.

Top module: `pat_qual_trig`

## Requirements
- R1: The pattern is present when, for every bit i with `care_i[i]`=1, `sense_i[i]` equals `want_i[i]`. Bits with `care_i[i]`=0 are ignored, and with all care bits 0 the pattern is always present.
- R2: With `mode_i`=0, `trig_o` pulses when the pattern goes from absent to present.
- R3: With `mode_i`=1, `trig_o` pulses when the pattern goes from present to absent.
- R4: Inputs are registered, so `trig_o` is high during the first clock cycle after the edge that samples the causing input change. It is a single-cycle pulse and is low during reset.
- R5: With `mode_i`=2 (state-qualified), a selected source edge triggers only while the pattern is present. Once the pattern is lost, edges no longer trigger.
- R6: With `mode_i`=3 (edge-qualified), the appearance of the pattern arms the trigger, which then fires on a later source edge even if the pattern has gone. The arm clears after that trigger.
- R7: `src_pol_i`=1 selects rising source edges and 0 selects falling edges. Source edges are detected on the registered source bit, in step with the registered pattern.
- R8: In the qualified modes, a source edge in the same cycle as the pattern's appearance does not trigger. That appearance restarts the cycle and edge counters.
- R9: With `wait_sel_i`=1, a source edge triggers only if at least `wait_lim_i` cycles have elapsed since the onset cycle. The cycle right after the onset cycle counts as 1.
- R10: With `wait_sel_i`=2, the trigger fires on the source edge whose count since the last onset reaches `wait_lim_i`. Values 0 and 1 mean the first edge, and the limit can be as large as 99,999,999.
- R11: With `within_en_i`=1, a source edge triggers only if no more than `within_lim_i` cycles have elapsed since the onset cycle, counted as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sense_i | input | NUM_IN | Comparator bits |
| care_i | input | NUM_IN | 1 = bit is compared |
| want_i | input | NUM_IN | Required level of each compared bit |
| src_i | input | 1 | Trigger source bit for the qualified modes |
| src_pol_i | input | 1 | 1 = rising, 0 = falling source edge |
| mode_i | input | 2 | 0 enter, 1 exit, 2 state-qualified, 3 edge-qualified |
| wait_sel_i | input | 2 | 0 none, 1 cycle wait, 2 edge-count wait |
| wait_lim_i | input | CNT_W | Wait limit in cycles or source edges |
| within_en_i | input | 1 | Enables the late-edge window |
| within_lim_i | input | CNT_W | Window length in cycles |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
A table steps the pattern modes through partial masks, full masks and an all-ignore mask. Bits that are ignored are toggled while compared bits flip, which separates a correct mask from one that compares every bit, and separates entry detection from exit detection. Directed sequences then move the source edge relative to pattern onset. They place it in the onset cycle, after the pattern is lost, just before and exactly at the wait limit, just past the window, and as the second edge after an edge-qualified trigger. These cases separate the state-qualified behaviour from the edge-qualified one and expose off-by-one errors in the counters.

// File: rtl/pqt_pkg.sv
package pqt_pkg;
  typedef enum logic [1:0] {
    MODE_ENTER = 2'd0,
    MODE_EXIT  = 2'd1,
    MODE_STATE = 2'd2,
    MODE_EDGE  = 2'd3
  } trig_mode_e;

  typedef enum logic [1:0] {
    WAIT_NONE   = 2'd0,
    WAIT_CYCLES = 2'd1,
    WAIT_EDGES  = 2'd2,
    WAIT_RSVD   = 2'd3
  } wait_kind_e;
endpackage

// File: rtl/pqt_pattern.sv
module pqt_pattern #(
  parameter int NUM_IN = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] sense_i,
  input  logic [NUM_IN-1:0] care_i,
  input  logic [NUM_IN-1:0] want_i,
  output logic              present_o,
  output logic              onset_o,
  output logic              offset_o
);
  logic [NUM_IN-1:0] bit_ok;
  logic match, pat_q, pat_prev_q;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_bit
    assign bit_ok[i] = ~care_i[i] | (sense_i[i] == want_i[i]);
  end

  assign match = &bit_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_q      <= 1'b0;
      pat_prev_q <= 1'b0;
    end else begin
      pat_q      <= match;
      pat_prev_q <= pat_q;
    end
  end

  assign present_o = pat_q;
  assign onset_o   = pat_q & ~pat_prev_q;
  assign offset_o  = ~pat_q & pat_prev_q;
endmodule

// File: rtl/pqt_edge.sv
module pqt_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic rise_i,
  output logic evt_o
);
  logic src_q, src_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q      <= 1'b0;
      src_prev_q <= 1'b0;
    end else begin
      src_q      <= src_i;
      src_prev_q <= src_q;
    end
  end

  assign evt_o = rise_i ? (src_q & ~src_prev_q) : (~src_q & src_prev_q);
endmodule

// File: rtl/pqt_qual.sv
module pqt_qual
  import pqt_pkg::*;
#(
  parameter int CNT_W = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  trig_mode_e       mode_i,
  input  wait_kind_e       wait_i,
  input  logic [CNT_W-1:0] wait_lim_i,
  input  logic             within_en_i,
  input  logic [CNT_W-1:0] within_lim_i,
  input  logic             present_i,
  input  logic             onset_i,
  input  logic             evt_i,
  output logic             fire_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  logic             arm_q;
  logic [CNT_W-1:0] cyc_q, edges_q;
  logic [CNT_W:0]   edges_next;
  logic             qual, active, time_ok, count_ok, within_ok, is_edge;

  assign is_edge = (mode_i == MODE_EDGE);

  always_comb begin
    unique case (mode_i)
      MODE_STATE: qual = present_i;
      MODE_EDGE:  qual = arm_q;
      default:    qual = 1'b0;
    endcase
  end

  // onset cycle restarts the counters and never fires
  assign active     = qual & ~onset_i;
  assign edges_next = {1'b0, edges_q} + {{CNT_W{1'b0}}, 1'b1};
  assign time_ok    = (wait_i != WAIT_CYCLES) | (cyc_q >= wait_lim_i);
  assign count_ok   = (wait_i != WAIT_EDGES) | (edges_next >= {1'b0, wait_lim_i});
  assign within_ok  = ~within_en_i | (cyc_q <= within_lim_i);
  assign fire_o     = active & evt_i & time_ok & count_ok & within_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q   <= '0;
      edges_q <= '0;
      arm_q   <= 1'b0;
    end else begin
      if (onset_i)                     cyc_q <= ONE;
      else if (active && cyc_q != SAT) cyc_q <= cyc_q + ONE;

      if (onset_i)                                edges_q <= '0;
      else if (active && evt_i && edges_q != SAT) edges_q <= edges_q + ONE;

      if (onset_i && is_edge)       arm_q <= 1'b1;
      else if (fire_o || !is_edge)  arm_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pat_qual_trig.sv
module pat_qual_trig
  import pqt_pkg::*;
#(
  parameter int NUM_IN = 5,
  parameter int CNT_W  = 27
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] sense_i,
  input  logic [NUM_IN-1:0] care_i,
  input  logic [NUM_IN-1:0] want_i,
  input  logic              src_i,
  input  logic              src_pol_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        wait_sel_i,
  input  logic [CNT_W-1:0]  wait_lim_i,
  input  logic              within_en_i,
  input  logic [CNT_W-1:0]  within_lim_i,
  output logic              trig_o
);
  trig_mode_e mode;
  wait_kind_e wait_kind;
  logic present, onset, offset, evt, qual_fire;

  assign mode      = trig_mode_e'(mode_i);
  assign wait_kind = wait_kind_e'(wait_sel_i);

  pqt_pattern #(.NUM_IN(NUM_IN)) u_pattern (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sense_i   (sense_i),
    .care_i    (care_i),
    .want_i    (want_i),
    .present_o (present),
    .onset_o   (onset),
    .offset_o  (offset)
  );

  pqt_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .rise_i (src_pol_i),
    .evt_o  (evt)
  );

  pqt_qual #(.CNT_W(CNT_W)) u_qual (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode),
    .wait_i       (wait_kind),
    .wait_lim_i   (wait_lim_i),
    .within_en_i  (within_en_i),
    .within_lim_i (within_lim_i),
    .present_i    (present),
    .onset_i      (onset),
    .evt_i        (evt),
    .fire_o       (qual_fire)
  );

  always_comb begin
    unique case (mode)
      MODE_ENTER: trig_o = onset;
      MODE_EXIT:  trig_o = offset;
      default:    trig_o = qual_fire;
    endcase
  end
endmodule

// File: rtl/pqt_checker.sv
module pqt_checker #(
  parameter int NUM_IN = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_IN-1:0] sense_i,
  input logic [NUM_IN-1:0] care_i,
  input logic [NUM_IN-1:0] want_i,
  input logic              src_i,
  input logic              src_pol_i,
  input logic [1:0]        mode_i,
  input logic              trig_o
);
  logic match;
  assign match = &(~care_i | ~(sense_i ^ want_i));

  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(trig_o) && $stable(mode_i) |-> !trig_o); // R4
  AST_ENTER_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o && mode_i == 2'd0 |-> $past(match)); // R2
  AST_EXIT_NOMATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o && mode_i == 2'd1 |-> !$past(match)); // R3
  AST_STATE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o && mode_i == 2'd2 |-> $past(match)); // R5
  AST_SRC_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o && mode_i[1] |-> $past(src_i) == src_pol_i); // R7
endmodule

bind pat_qual_trig pqt_checker #(.NUM_IN(NUM_IN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sense_i   (sense_i),
  .care_i    (care_i),
  .want_i    (want_i),
  .src_i     (src_i),
  .src_pol_i (src_pol_i),
  .mode_i    (mode_i),
  .trig_o    (trig_o)
);

// File: tb/pat_qual_trig_test.sv
module pat_qual_trig_test;
  localparam int NUM_IN = 5;
  localparam int CNT_W  = 27;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NUM_IN-1:0] sense = '0, care = '0, want = '0;
  logic              src = 1'b0, src_pol = 1'b1, within_en = 1'b0;
  logic [1:0]        mode = 2'd0, wait_sel = 2'd0;
  logic [CNT_W-1:0]  wait_lim = '0, within_lim = '0;
  logic              trig;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pat_qual_trig #(.NUM_IN(NUM_IN), .CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sense_i(sense), .care_i(care), .want_i(want),
    .src_i(src), .src_pol_i(src_pol), .mode_i(mode), .wait_sel_i(wait_sel),
    .wait_lim_i(wait_lim), .within_en_i(within_en), .within_lim_i(within_lim),
    .trig_o(trig)
  );

  typedef struct packed {
    logic [1:0] md;
    logic [4:0] cr;
    logic [4:0] wn;
    logic [4:0] sn;
    logic       ex;
  } vec_t;

  // R1 masks: cr selects compared bits, wn their levels
  localparam vec_t VECS [12] = '{
    '{2'd0, 5'b00011, 5'b00001, 5'b00000, 1'b0},
    '{2'd0, 5'b00011, 5'b00001, 5'b00001, 1'b1},
    '{2'd0, 5'b00011, 5'b00001, 5'b11101, 1'b0},
    '{2'd0, 5'b00011, 5'b00001, 5'b00011, 1'b0},
    '{2'd0, 5'b00011, 5'b00001, 5'b00001, 1'b1},
    '{2'd1, 5'b00011, 5'b00001, 5'b00001, 1'b0},
    '{2'd1, 5'b00011, 5'b00001, 5'b00000, 1'b1},
    '{2'd1, 5'b00011, 5'b00001, 5'b00000, 1'b0},
    '{2'd1, 5'b00000, 5'b00001, 5'b00000, 1'b0},
    '{2'd0, 5'b11111, 5'b10101, 5'b10101, 1'b0},
    '{2'd0, 5'b11111, 5'b10101, 5'b10100, 1'b0},
    '{2'd0, 5'b11111, 5'b10101, 5'b10101, 1'b1}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s trig_o=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic step(input logic [NUM_IN-1:0] s, input logic sr, input logic exp,
                      input string req);
    sense = s;
    src   = sr;
    @(posedge clk);
    #1;
    chk(req, trig, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // reset: matching inputs, no pulse
    care = 5'b00011; want = 5'b00001; sense = 5'b00001;
    repeat (3) @(posedge clk);
    #1;
    chk("R4 reset", trig, 1'b0);
    sense = 5'b00000;
    rst_ni = 1'b1;

    for (int i = 0; i < 12; i++) begin
      mode = VECS[i].md;
      care = VECS[i].cr;
      want = VECS[i].wn;
      step(VECS[i].sn, 1'b0, VECS[i].ex, VECS[i].md == 2'd0 ? "R1 R2 table" : "R1 R3 table");
    end

    // qualified: bit0 must be high
    care = 5'b00001; want = 5'b00001;

    // state-qualified
    mode = 2'd2; wait_sel = 2'd0; within_en = 1'b0; src_pol = 1'b1;
    step(5'b0, 1'b0, 1'b0, "R5");
    step(5'b1, 1'b0, 1'b0, "R8");
    step(5'b1, 1'b1, 1'b1, "R5");
    step(5'b1, 1'b0, 1'b0, "R5");
    step(5'b1, 1'b1, 1'b1, "R5 repeat");
    step(5'b0, 1'b0, 1'b0, "R5");
    step(5'b0, 1'b1, 1'b0, "R5 pattern lost");
    step(5'b0, 1'b0, 1'b0, "R8");
    step(5'b1, 1'b1, 1'b0, "R8 onset cycle edge");

    // edge-qualified
    mode = 2'd3;
    step(5'b0, 1'b0, 1'b0, "R6");
    step(5'b1, 1'b0, 1'b0, "R6");
    step(5'b0, 1'b0, 1'b0, "R6");
    step(5'b0, 1'b1, 1'b1, "R6 armed without pattern");
    step(5'b0, 1'b0, 1'b0, "R6");
    step(5'b0, 1'b1, 1'b0, "R6 arm cleared");

    // falling source edge
    mode = 2'd2; src_pol = 1'b0;
    step(5'b0, 1'b1, 1'b0, "R7");
    step(5'b1, 1'b1, 1'b0, "R7");
    step(5'b1, 1'b0, 1'b1, "R7 falling");
    step(5'b1, 1'b1, 1'b0, "R7 rising ignored");

    // cycle wait of 3
    src_pol = 1'b1; wait_sel = 2'd1; wait_lim = 27'd3;
    step(5'b0, 1'b0, 1'b0, "R9");
    step(5'b1, 1'b0, 1'b0, "R9");
    step(5'b1, 1'b1, 1'b0, "R9 early");
    step(5'b1, 1'b0, 1'b0, "R9");
    step(5'b1, 1'b1, 1'b1, "R9 at limit");

    // edge-count wait of 3
    wait_sel = 2'd2; wait_lim = 27'd3;
    step(5'b0, 1'b0, 1'b0, "R10");
    step(5'b1, 1'b0, 1'b0, "R10");
    step(5'b1, 1'b1, 1'b0, "R10 first");
    step(5'b1, 1'b0, 1'b0, "R10");
    step(5'b1, 1'b1, 1'b0, "R10 second");
    step(5'b1, 1'b0, 1'b0, "R10");
    step(5'b1, 1'b1, 1'b1, "R10 third");
    step(5'b0, 1'b0, 1'b0, "R10");
    step(5'b1, 1'b0, 1'b0, "R10");
    step(5'b1, 1'b1, 1'b0, "R10 count restarted");

    // window of 2 cycles
    wait_sel = 2'd0; within_en = 1'b1; within_lim = 27'd2;
    step(5'b0, 1'b0, 1'b0, "R11");
    step(5'b1, 1'b0, 1'b0, "R11");
    step(5'b1, 1'b0, 1'b0, "R11");
    step(5'b1, 1'b0, 1'b0, "R11");
    step(5'b1, 1'b1, 1'b0, "R11 too late");
    step(5'b0, 1'b0, 1'b0, "R11");
    step(5'b1, 1'b0, 1'b0, "R11");
    step(5'b1, 1'b1, 1'b1, "R11 in window");

    finish_run();
  end
endmodule